// File: doc/BRIEF.md
# Frame-buffer pixel unpacker

This block sits in the read path of a display controller, between the frame-buffer fetch logic and the panel interface. It receives 32-bit words over a valid/ready stream and returns one pixel per handshake over a second valid/ready stream. A start-of-line strobe loads a pixel format, an 18-bit panel select, a colour-enhancement flag and a line length. The block then emits exactly that many pixels and stops until the next strobe.

All formats are true colour: the stored bits map straight to red, green and blue with no lookup table. The 16-bit formats (12-bit 4:4:4 in the low 12 bits, intensity plus 5:5:5, and 5:6:5) place two pixels in each word. The 24-bit format is stored either as one pixel per word with a spare top byte, or as a packed byte stream in which pixels cross word boundaries. The packed form is handled by a small byte holding register that keeps leftover bytes from one word for the next.

Top module: `pix_unpack`

## Requirements
- R1: After reset, and until a start-of-line strobe with a non-zero length arrives, `out_valid` and `in_ready` stay low.
- R2: Format code 2 (5:6:5, red in bits 15:11, green in 10:5, blue in 4:0) takes two pixels per word, the bits 15:0 pixel first. On a 24-bit panel each field widens by repeating its top bits: red and blue 5-bit v become {v, v[4:2]}, green 6-bit g becomes {g, g[5:4]}.
- R3: Format code 0 (4:4:4, red in 11:8, green 7:4, blue 3:0 of each halfword; bits 15:12 ignored) widens each 4-bit v to {v, v} on a 24-bit panel and to {v, v[3:2]} on an 18-bit panel.
- R4: Format code 1 (intensity in bit 15, red 14:10, green 9:5, blue 4:0) appends the intensity bit as the least significant bit of every component: a 5-bit v becomes {v, i} on an 18-bit panel and {v, v[4:3], i} on a 24-bit panel.
- R5: Format code 3 takes one pixel per word from bits 23:0 (red 23:16, green 15:8, blue 7:0) and ignores bits 31:24.
- R6: Format code 4 reads pixels as a little-endian byte stream, 3 bytes each, blue byte first. Three words yield four pixels, and partial pixels carry across word boundaries.
- R7: With the 18-bit panel select set, the pixel is {red6, green6, blue6} in `out_pix[17:0]` and `out_pix[23:18]` is zero. For 24-bit formats each component keeps its top 6 bits. For 5:6:5, enhancement on makes red and blue {v, v[4]}; enhancement off makes them {v, 0}.
- R8: A line emits exactly the programmed number of pixels, from 1 up to 1024. It consumes exactly ceil(pixels x bytes-per-pixel / 4) words; bytes per pixel are 2, 4 and 3 for the 16-bit, unpacked and packed formats. After the last pixel, no word is accepted and no pixel is offered until the next strobe.
- R9: A start-of-line strobe discards any bytes held from the previous line, including a line cut short.
- R10: Format, panel select and enhancement inputs are sampled only at the strobe. Changing them mid-line has no effect on the current line.
- R11: Under output backpressure a pixel offered stays offered and unchanged until taken. No pixel is dropped or repeated.
- R12: A strobe with a line length of 0 leaves the block idle, with no word accepted and no pixel offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sol | input | 1 | Start-of-line strobe; loads configuration and clears the holding register |
| fmt_in | input | 3 | Pixel format code (0 4:4:4, 1 I:5:5:5, 2 5:6:5, 3 24-bit unpacked, 4 24-bit packed, 5-7 treated as 5:6:5) |
| enh_in | input | 1 | Colour enhancement for 5:6:5 on an 18-bit panel |
| p18_in | input | 1 | Select 18-bit panel output |
| line_len | input | 11 | Pixels in the coming line (values above 1024 clamp to 1024) |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| in_data | input | 32 | Frame-buffer word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Pixel sink ready |
| out_pix | output | 24 | Pixel, RGB888 or zero-extended RGB666 |

## Verification
Emitting a pixel and accepting a new word can fall in the same cycle. This happens when the pop of the last whole pixel in the holding register frees room and `in_ready` rises combinationally from `out_ready`. The bench provokes it with random gaps on both `in_valid` and `out_ready` across all formats, most often in packed 24-bit lines where the fill level cycles through every residue. Each pixel is compared, in order, with a value computed from the byte stream the bench sent. The count of accepted words is checked at line end, so a byte that was lost, doubled or misaligned at the overlap shows up as a wrong pixel or a wrong word count.

// File: rtl/pu_pkg.sv
package pu_pkg;

   typedef enum logic [2:0] {
      PF_RGB444   = 3'd0,
      PF_IRGB1555 = 3'd1,
      PF_RGB565   = 3'd2,
      PF_RGB888U  = 3'd3,
      PF_RGB888P  = 3'd4
   } pix_fmt_e;

   // Bytes of frame-buffer storage consumed by one pixel.
   function automatic logic [2:0] bytes_per_pix(input logic [2:0] fmt);
      case (fmt)
         PF_RGB888U: bytes_per_pix = 3'd4;
         PF_RGB888P: bytes_per_pix = 3'd3;
         default:    bytes_per_pix = 3'd2;
      endcase
   endfunction

endpackage

// File: rtl/pu_fmt_map.sv
module pu_fmt_map
   import pu_pkg::*;
(
   input  logic [31:0] raw_i,
   input  logic [2:0]  fmt_i,
   input  logic        enh_i,
   input  logic        p18_i,
   output logic [23:0] pix_o
);

   logic [15:0] hw;
   logic [23:0] tc;

   assign hw = raw_i[15:0];
   assign tc = raw_i[23:0];

   always_comb begin
      case (fmt_i)
         PF_RGB444: begin
            if (p18_i)
               pix_o = {6'd0, hw[11:8], hw[11:10], hw[7:4], hw[7:6], hw[3:0], hw[3:2]};
            else
               pix_o = {hw[11:8], hw[11:8], hw[7:4], hw[7:4], hw[3:0], hw[3:0]};
         end
         PF_IRGB1555: begin
            if (p18_i)
               pix_o = {6'd0, hw[14:10], hw[15], hw[9:5], hw[15], hw[4:0], hw[15]};
            else
               pix_o = {hw[14:10], hw[14:13], hw[15],
                        hw[9:5],   hw[9:8],   hw[15],
                        hw[4:0],   hw[4:3],   hw[15]};
         end
         PF_RGB888U, PF_RGB888P: begin
            if (p18_i)
               pix_o = {6'd0, tc[23:18], tc[15:10], tc[7:2]};
            else
               pix_o = tc;
         end
         default: begin
            if (p18_i)
               pix_o = {6'd0, hw[15:11], enh_i & hw[15], hw[10:5], hw[4:0], enh_i & hw[4]};
            else
               pix_o = {hw[15:11], hw[15:13], hw[10:5], hw[10:9], hw[4:0], hw[4:2]};
         end
      endcase
   end

endmodule

// File: rtl/pu_bytebuf.sv
module pu_bytebuf #(
   parameter  int WORD_BYTES = 4,
   localparam int BUF_BYTES  = 2 * WORD_BYTES - 1,
   localparam int BUF_W      = 8 * BUF_BYTES,
   localparam int CNT_W      = $clog2(BUF_BYTES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_i,
   input  logic                    pop_i,
   input  logic [CNT_W-1:0]        pop_bytes_i,
   input  logic                    push_i,
   input  logic [8*WORD_BYTES-1:0] word_i,
   output logic [8*WORD_BYTES-1:0] head_o,
   output logic [CNT_W-1:0]        cnt_o,
   output logic [CNT_W-1:0]        after_o
);

   if (WORD_BYTES < 2) begin : g_bad_word
      $error("pu_bytebuf: WORD_BYTES must be at least 2");
   end

   logic [BUF_W-1:0] hold_q;
   logic [BUF_W-1:0] shifted;
   logic [BUF_W-1:0] inserted;
   logic [CNT_W-1:0] cnt_q;

   assign after_o  = pop_i ? cnt_q - pop_bytes_i : cnt_q;
   assign shifted  = pop_i ? (hold_q >> {pop_bytes_i, 3'b000}) : hold_q;
   assign inserted = {{(BUF_W - 8*WORD_BYTES){1'b0}}, word_i} << {after_o, 3'b000};
   assign head_o   = hold_q[8*WORD_BYTES-1:0];
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         cnt_q  <= '0;
      end else if (clr_i) begin
         hold_q <= '0;
         cnt_q  <= '0;
      end else begin
         hold_q <= push_i ? (shifted | inserted) : shifted;
         cnt_q  <= push_i ? after_o + CNT_W'(WORD_BYTES) : after_o;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !clr_i) |-> (after_o <= CNT_W'(BUF_BYTES - WORD_BYTES))) else $error("buffer overflow"); // R11
   AST_POP_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> (cnt_q >= pop_bytes_i)) else $error("partial pixel popped"); // R11

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
   import pu_pkg::*;
#(
   parameter  int MAX_LINE   = 1024,
   localparam int WORD_BYTES = 4,
   localparam int LEN_W      = $clog2(MAX_LINE + 1),
   localparam int CNT_W      = $clog2(2 * WORD_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sol,
   input  logic [2:0]       fmt_in,
   input  logic             enh_in,
   input  logic             p18_in,
   input  logic [LEN_W-1:0] line_len,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [31:0]      in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [23:0]      out_pix
);

   if (MAX_LINE < 1) begin : g_bad_len
      $error("pix_unpack: MAX_LINE must be positive");
   end

   logic             act_q;
   logic [LEN_W-1:0] left_q;
   logic [2:0]       fmt_q;
   logic             enh_q;
   logic             p18_q;

   logic [CNT_W-1:0] bpp;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] after;
   logic [31:0]      head;
   logic             pop;
   logic             push;
   logic             last;

   assign bpp       = CNT_W'(bytes_per_pix(fmt_q));
   assign last      = (left_q == LEN_W'(1));
   assign out_valid = act_q && !sol && (cnt >= bpp);
   assign pop       = out_valid && out_ready;
   assign in_ready  = act_q && !sol && !(pop && last) && (after < bpp);
   assign push      = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         left_q <= '0;
         fmt_q  <= PF_RGB565;
         enh_q  <= 1'b0;
         p18_q  <= 1'b0;
      end else if (sol) begin
         fmt_q  <= fmt_in;
         enh_q  <= enh_in;
         p18_q  <= p18_in;
         left_q <= (line_len > LEN_W'(MAX_LINE)) ? LEN_W'(MAX_LINE) : line_len;
         act_q  <= (line_len != '0);
      end else if (pop) begin
         left_q <= left_q - LEN_W'(1);
         if (last) act_q <= 1'b0;
      end
   end

   pu_bytebuf #(.WORD_BYTES(WORD_BYTES)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (sol || (pop && last)),
      .pop_i      (pop),
      .pop_bytes_i(bpp),
      .push_i     (push),
      .word_i     (in_data),
      .head_o     (head),
      .cnt_o      (cnt),
      .after_o    (after)
   );

   pu_fmt_map u_map (
      .raw_i(head),
      .fmt_i(fmt_q),
      .enh_i(enh_q),
      .p18_i(p18_q),
      .pix_o(out_pix)
   );

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (sol || (out_valid && $stable(out_pix)))) else $error("stalled pixel changed"); // R11
   AST_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && last) |=> (sol || (!out_valid && !in_ready))) else $error("activity after line end"); // R8
   AST_SOL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      sol |=> !out_valid) else $error("pixel right after strobe"); // R9
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sol |=> ($stable(fmt_q) && $stable(p18_q) && $stable(enh_q))) else $error("config moved mid-line"); // R10
   AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (sol && line_len == '0) |=> (!in_ready && !out_valid)) else $error("zero line not idle"); // R12

endmodule

// File: tb/sim_pix_unpack.sv
module sim_pix_unpack;

   localparam int CLK_PER = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sol = 1'b0;
   logic [2:0]  fmt_in = 3'd0;
   logic        enh_in = 1'b0;
   logic        p18_in = 1'b0;
   logic [10:0] line_len = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [23:0] out_pix;

   int n_chk = 0;
   int n_bad = 0;
   bit done_f = 1'b0;

   pix_unpack u0 (
      .clk(clk), .rst_n(rst_n), .sol(sol), .fmt_in(fmt_in), .enh_in(enh_in),
      .p18_in(p18_in), .line_len(line_len), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
   );

   always #(CLK_PER/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int bpp_of(input int f);
      if (f == 3) return 4;
      if (f == 4) return 3;
      return 2;
   endfunction

   function automatic logic [23:0] model(input int f, input bit e, input bit p,
                                         input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
      int h, r8, g8, c8, r6, g6, c6, r, g, c, i;
      h = {b1, b0};
      if (f == 0) begin
         r = (h >> 8) & 15; g = (h >> 4) & 15; c = h & 15;
         r8 = r * 17; g8 = g * 17; c8 = c * 17;
         r6 = r * 4 + r / 4; g6 = g * 4 + g / 4; c6 = c * 4 + c / 4;
      end else if (f == 1) begin
         i = (h >> 15) & 1; r = (h >> 10) & 31; g = (h >> 5) & 31; c = h & 31;
         r6 = r * 2 + i; g6 = g * 2 + i; c6 = c * 2 + i;
         r8 = r * 8 + (r / 8) * 2 + i; g8 = g * 8 + (g / 8) * 2 + i; c8 = c * 8 + (c / 8) * 2 + i;
      end else if (f == 3 || f == 4) begin
         r8 = b2; g8 = b1; c8 = b0;
         r6 = r8 / 4; g6 = g8 / 4; c6 = c8 / 4;
      end else begin
         r = (h >> 11) & 31; g = (h >> 5) & 63; c = h & 31;
         r8 = r * 8 + r / 4; g8 = g * 4 + g / 16; c8 = c * 8 + c / 4;
         r6 = r * 2 + (e ? r / 16 : 0); g6 = g; c6 = c * 2 + (e ? c / 16 : 0);
      end
      if (p) return {6'd0, 6'(r6), 6'(g6), 6'(c6)};
      return {8'(r8), 8'(g8), 8'(c8)};
   endfunction

   task automatic run_line(input string tag, input int f, input bit e, input bit p,
                           input int len, input int stop_after, input bit scramble);
      int bpp, nwords, wi, got, cyc, base;
      logic [31:0] w[];
      logic [7:0]  by[];
      bit prev_stall;
      logic [23:0] prev_pix, exp;
      bpp    = bpp_of(f);
      nwords = (len * bpp + 3) / 4;
      w  = new[nwords + 2];
      by = new[4 * (nwords + 2)];
      foreach (w[k]) begin
         w[k] = $urandom;
         for (int j = 0; j < 4; j++) by[4*k + j] = w[k][8*j +: 8];
      end
      @(negedge clk);
      sol = 1'b1; fmt_in = 3'(f); enh_in = e; p18_in = p; line_len = 11'(len);
      in_valid = 1'b0; out_ready = 1'b0;
      @(negedge clk);
      sol = 1'b0;
      if (scramble) begin
         fmt_in = 3'($urandom % 8); enh_in = 1'($urandom); p18_in = 1'($urandom);
      end
      wi = 0; got = 0; cyc = 0; prev_stall = 1'b0; prev_pix = '0;
      while (got < stop_after && cyc < len * 8 + 100) begin
         in_valid  = (wi < nwords + 2) && ($urandom % 4 != 0);
         in_data   = w[(wi < nwords + 2) ? wi : 0];
         out_ready = ($urandom % 4 != 0);
         #1;
         if (prev_stall)
            chk(out_valid && out_pix == prev_pix, {tag, " R11 stalled pixel held"}, {8'd0, out_pix}, {8'd0, prev_pix});
         if (in_valid && in_ready) wi++;
         if (out_valid && out_ready) begin
            base = (f == 3) ? 4 * got : bpp * got;
            exp  = model(f, e, p, by[base], by[base+1], by[base+2]);
            chk(out_pix == exp, tag, {8'd0, out_pix}, {8'd0, exp});
            got++;
         end
         prev_stall = out_valid && !out_ready;
         prev_pix   = out_pix;
         @(negedge clk);
         cyc++;
      end
      if (got < stop_after) chk(1'b0, {tag, " line watchdog"}, got, stop_after);
      if (stop_after == len) begin
         chk(wi == nwords, {tag, " R8 words consumed"}, wi, nwords);
         for (int t = 0; t < 4; t++) begin
            in_valid = 1'b1; in_data = w[nwords]; out_ready = 1'b1;
            #1;
            chk(!in_ready && !out_valid, {tag, " R8 idle after last pixel"},
                {in_ready, out_valid}, 0);
            @(negedge clk);
         end
      end
      in_valid = 1'b0; out_ready = 1'b0;
   endtask

   initial begin
      #(CLK_PER * 190000);
      if (!done_f) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      in_valid = 1'b1; out_ready = 1'b1;
      for (int t = 0; t < 3; t++) begin
         @(negedge clk); #1;
         chk(!in_ready && !out_valid, "R1 idle after reset", {in_ready, out_valid}, 0);
      end
      in_valid = 1'b0;
      run_line("R2 rgb565 to 888",        2, 0, 0, 6, 6, 0);
      run_line("R3 rgb444 to 888 odd",    0, 0, 0, 5, 5, 0);
      run_line("R3 rgb444 to 666",        0, 0, 1, 4, 4, 0);
      run_line("R4 irgb1555 to 888",      1, 0, 0, 8, 8, 0);
      run_line("R4 irgb1555 to 666",      1, 0, 1, 6, 6, 0);
      run_line("R5 rgb888 unpacked",      3, 0, 0, 5, 5, 0);
      run_line("R6 rgb888 packed",        4, 0, 0, 8, 8, 0);
      run_line("R6 rgb888 packed odd",    4, 0, 0, 7, 7, 0);
      run_line("R7 rgb565 666 enhanced",  2, 1, 1, 6, 6, 0);
      run_line("R7 rgb565 666 plain",     2, 0, 1, 6, 6, 0);
      run_line("R7 rgb888 packed 666",    4, 0, 1, 5, 5, 0);
      run_line("R9 packed line cut",      4, 0, 0, 8, 1, 0);
      run_line("R9 packed after cut",     4, 0, 0, 4, 4, 0);
      run_line("R12 zero length",         2, 0, 0, 0, 0, 0);
      run_line("R8 full 1024 packed",     4, 0, 0, 1024, 1024, 0);
      for (int n = 0; n < 30; n++) begin
         int f, len;
         f   = $urandom % 5;
         len = 1 + $urandom % 40;
         run_line("R10 random line scrambled cfg", f, 1'($urandom), 1'($urandom), len, len, 1);
      end
      done_f = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule